// File: doc/BRIEF.md
# Frame slip elastic store

This block sits between a digital trunk receiver and the local switching fabric. Bits arrive with a write strobe paced by the recovered line rate. They leave with a read strobe paced by local system timing. Both strobes are single-cycle enables on one shared clock. The store holds two frames of bits and is meant to run about one frame deep.

When the two rates drift apart, the block corrects the difference in whole-frame steps, so the frame alignment seen by the reader is never disturbed. A fast writer causes one unread frame to be dropped. A slow writer causes the frame that was just read to be played again. Every correction raises a one-cycle indication and bumps a saturating event counter, which a clear input can zero.

The frame length is a parameter. Typical values are 256 bits for a 2 Mb/s link and 193 bits for a 1.5 Mb/s link. The storage depth is always twice the frame length, and it need not be a power of two.

Top module: `frame_slip_store`

## Requirements
- R1: While reset is asserted and in the first cycle after release, rd_bit, slip_del and slip_rep are 0 and slip_cnt is 0.
- R2: Read strobes are ignored until FRAME_BITS bits have been accepted. Each such strobe leaves rd_bit at 0 and consumes nothing. The first read after that returns the first bit written.
- R3: The register rd_bit changes only on the edge that samples rd_en. With no slip it returns accepted bits in write order. A write and a read in the same cycle both take effect and leave the fill level unchanged.
- R4: A frame boundary is the read that completes FRAME_BITS reads since the previous boundary. If the fill level after such a read exceeds 2*FRAME_BITS - floor(FRAME_BITS/4), the next FRAME_BITS unread bits are discarded and slip_del is 1 for exactly the following cycle.
- R5: If the fill level after a boundary read is below floor(FRAME_BITS/4), the FRAME_BITS bits just read are delivered again before any newer bit, and slip_rep is 1 for exactly the following cycle.
- R6: A slip occurs only on a boundary read, always moves exactly FRAME_BITS bits, and slip_del and slip_rep are never 1 together.
- R7: slip_cnt increases by one on the same edge that raises slip_del or slip_rep, and stays at 2^CNT_W-1 once it gets there.
- R8: clr_cnt zeroes slip_cnt on the next edge and takes priority over a slip in the same cycle.
- R9: A write while the store is full and no read is accepted is dropped. After priming, a read while the store is empty drives rd_bit to 0 and does not advance the frame position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the line side |
| wr_bit | input | 1 | Data bit written with wr_en |
| rd_en | input | 1 | Read strobe from the local side |
| rd_bit | output | 1 | Registered bit returned for the last read strobe |
| clr_cnt | input | 1 | Zeroes the slip counter |
| slip_del | output | 1 | One-cycle pulse: a frame was discarded |
| slip_rep | output | 1 | One-cycle pulse: a frame will be repeated |
| slip_cnt | output | CNT_W | Saturating count of slips |

## Verification
The bench drives a writer that is faster than the reader, then one that is slower. If the thresholds or the boundary test were misplaced, the pulses would come at the wrong read or a frame would be cut mid-way, and the returned bit stream would diverge from the queue model at the first slip. The frame length chosen makes the depth a non power of two. A pointer that wraps at the wrong place would therefore corrupt the repeated frame, which is replayed from the wrapped position. The bench also fills the store until it is full and drains it until it is empty, which exercises dropped writes and stalled reads. It clears the counter while slips keep coming and pushes the counter past saturation; a counter that wrapped, or a clear that lost against a slip, would show a wrong count.

// File: rtl/es_pkg.sv
package es_pkg;

   typedef enum logic [1:0] {
      SLIP_NONE = 2'd0,
      SLIP_DROP = 2'd1,
      SLIP_AGAIN = 2'd2
   } slip_kind_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/es_ring_add.sv
module es_ring_add #(
   parameter int DEPTH = 512,
   parameter int STEP  = 1,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic [AW-1:0] ptr_in,
   output logic [AW-1:0] ptr_out
);
   import es_pkg::*;

   if (STEP < 1 || STEP >= DEPTH) begin : g_bad_step
      $error("es_ring_add: STEP must lie in 1..DEPTH-1");
   end

   if (is_pow2(DEPTH)) begin : g_pow2
      // natural wrap of the pointer width
      assign ptr_out = ptr_in + AW'(STEP);
   end else begin : g_mod
      logic [AW:0] sum;
      always_comb begin
         sum = {1'b0, ptr_in} + (AW+1)'(STEP);
         if (sum >= (AW+1)'(DEPTH))
            ptr_out = AW'(sum - (AW+1)'(DEPTH));
         else
            ptr_out = sum[AW-1:0];
      end
   end

endmodule

// File: rtl/es_bit_ram.sv
module es_bit_ram #(
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wdata,
   input  logic [AW-1:0] raddr,
   output logic          rdata
);
   logic [DEPTH-1:0] cells;

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/es_ptr_ctrl.sv
module es_ptr_ctrl
   import es_pkg::*;
#(
   parameter int FRAME_BITS = 256,
   localparam int DEPTH     = 2 * FRAME_BITS,
   localparam int AW        = $clog2(DEPTH),
   localparam int FW        = $clog2(DEPTH + 1),
   localparam int OW        = $clog2(FRAME_BITS),
   localparam int LOW_MARK  = FRAME_BITS / 4,
   localparam int HIGH_MARK = DEPTH - FRAME_BITS / 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          wr_ok,
   output logic          rd_ok,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [FW-1:0] fill,
   output logic          primed,
   output slip_kind_e    slip_now,
   output logic          slip_del,
   output logic          slip_rep
);
   logic [AW-1:0] wptr_inc, rptr_inc, rptr_adv, rptr_jump;
   logic [OW-1:0] rd_off;
   logic [FW-1:0] fill_step;
   logic          at_edge, del_now, rep_now;

   // write and read pointers each step by one position
   es_ring_add #(.DEPTH(DEPTH), .STEP(1)) u_winc (.ptr_in(waddr), .ptr_out(wptr_inc));
   es_ring_add #(.DEPTH(DEPTH), .STEP(1)) u_rinc (.ptr_in(raddr), .ptr_out(rptr_inc));
   // one frame back equals one frame forward in a two-frame ring
   es_ring_add #(.DEPTH(DEPTH), .STEP(FRAME_BITS)) u_jump (.ptr_in(rptr_adv), .ptr_out(rptr_jump));

   always_comb begin
      rd_ok     = rd_en && primed && (fill != '0);
      wr_ok     = wr_en && ((fill != FW'(DEPTH)) || rd_ok);
      fill_step = fill + FW'(wr_ok) - FW'(rd_ok);
      rptr_adv  = rd_ok ? rptr_inc : raddr;
      at_edge   = rd_ok && (rd_off == OW'(FRAME_BITS - 1));
      rep_now   = at_edge && (fill_step < FW'(LOW_MARK));
      del_now   = at_edge && (fill_step > FW'(HIGH_MARK));
      if (del_now)      slip_now = SLIP_DROP;
      else if (rep_now) slip_now = SLIP_AGAIN;
      else              slip_now = SLIP_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waddr    <= '0;
         raddr    <= '0;
         rd_off   <= '0;
         fill     <= '0;
         primed   <= 1'b0;
         slip_del <= 1'b0;
         slip_rep <= 1'b0;
      end else begin
         if (wr_ok) waddr <= wptr_inc;
         raddr <= (rep_now || del_now) ? rptr_jump : rptr_adv;
         if (rd_ok) rd_off <= at_edge ? '0 : rd_off + 1'b1;
         if (rep_now)      fill <= fill_step + FW'(FRAME_BITS);
         else if (del_now) fill <= fill_step - FW'(FRAME_BITS);
         else              fill <= fill_step;
         if (!primed && (fill_step >= FW'(FRAME_BITS))) primed <= 1'b1;
         slip_del <= del_now;
         slip_rep <= rep_now;
      end
   end

endmodule

// File: rtl/es_slip_count.sv
module es_slip_count
   import es_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  slip_kind_e       slip_now,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)                                   count <= '0;
      else if (clr)                                 count <= '0;
      else if (slip_now != SLIP_NONE && count != TOP) count <= count + 1'b1;
   end

endmodule

// File: rtl/frame_slip_store.sv
module frame_slip_store
   import es_pkg::*;
#(
   parameter int FRAME_BITS = 256,
   parameter int CNT_W      = 16,
   localparam int DEPTH     = 2 * FRAME_BITS,
   localparam int AW        = $clog2(DEPTH),
   localparam int FW        = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_bit,
   input  logic             rd_en,
   output logic             rd_bit,
   input  logic             clr_cnt,
   output logic             slip_del,
   output logic             slip_rep,
   output logic [CNT_W-1:0] slip_cnt
);
   if (FRAME_BITS < 8) begin : g_chk_frame
      $error("frame_slip_store: FRAME_BITS must be at least 8");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("frame_slip_store: CNT_W must be at least 1");
   end

   logic          wr_ok, rd_ok, ram_q, primed;
   logic [AW-1:0] waddr, raddr;
   logic [FW-1:0] fill_lvl;
   slip_kind_e    slip_now;

   es_ptr_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .wr_ok(wr_ok), .rd_ok(rd_ok), .waddr(waddr), .raddr(raddr),
      .fill(fill_lvl), .primed(primed), .slip_now(slip_now),
      .slip_del(slip_del), .slip_rep(slip_rep)
   );

   es_bit_ram #(.DEPTH(DEPTH)) u_ram (
      .clk(clk), .we(wr_ok), .waddr(waddr), .wdata(wr_bit),
      .raddr(raddr), .rdata(ram_q)
   );

   es_slip_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .slip_now(slip_now), .count(slip_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_bit <= 1'b0;
      else if (rd_en) rd_bit <= rd_ok ? ram_q : 1'b0;
   end

endmodule

// File: rtl/es_chk.sv
module es_chk #(
   parameter int FRAME_BITS = 256,
   parameter int CNT_W      = 16,
   localparam int DEPTH     = 2 * FRAME_BITS,
   localparam int FW        = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic             clr_cnt,
   input logic             rd_bit,
   input logic             slip_del,
   input logic             slip_rep,
   input logic [CNT_W-1:0] slip_cnt,
   input logic [FW-1:0]    fill_lvl,
   input logic             primed
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(slip_del && slip_rep));

   a_r6_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (slip_del || slip_rep) |-> $past(rd_en));

   a_r4_del_single: assert property (@(posedge clk) disable iff (!rst_n)
      slip_del |=> !slip_del);

   a_r5_rep_single: assert property (@(posedge clk) disable iff (!rst_n)
      slip_rep |=> !slip_rep);

   a_r4_del_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      slip_del |-> (fill_lvl <= FW'(FRAME_BITS)));

   a_r5_rep_raises: assert property (@(posedge clk) disable iff (!rst_n)
      slip_rep |-> (fill_lvl >= FW'(FRAME_BITS)));

   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((slip_del || slip_rep) && !$past(clr_cnt) && $past(slip_cnt) != TOP)
         |-> (slip_cnt == $past(slip_cnt) + 1'b1));

   a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!slip_del && !slip_rep && !$past(clr_cnt)) |-> $stable(slip_cnt));

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cnt |=> (slip_cnt == '0));

   a_r9_fill_range: assert property (@(posedge clk) disable iff (!rst_n)
      fill_lvl <= FW'(DEPTH));

   a_r2_quiet_unprimed: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |-> (rd_bit == 1'b0));

endmodule

bind frame_slip_store es_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .clr_cnt(clr_cnt),
   .rd_bit(rd_bit), .slip_del(slip_del), .slip_rep(slip_rep),
   .slip_cnt(slip_cnt), .fill_lvl(fill_lvl), .primed(primed)
);

// File: tb/frame_slip_store_tb_top.sv
`timescale 1ns/1ps
module frame_slip_store_tb_top;
   localparam int FRAME = 12;
   localparam int CW    = 3;
   localparam int DEPTH = 2 * FRAME;
   localparam int LOW   = FRAME / 4;
   localparam int HIGH  = DEPTH - FRAME / 4;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0, clr_cnt = 1'b0;
   logic rd_bit, slip_del, slip_rep;
   logic [CW-1:0] slip_cnt;

   always #2.5 clk = ~clk;

   frame_slip_store #(.FRAME_BITS(FRAME), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
      .rd_bit(rd_bit), .clr_cnt(clr_cnt), .slip_del(slip_del),
      .slip_rep(slip_rep), .slip_cnt(slip_cnt)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;
   string cur_tag = "R1";

   // reference model state
   bit m_q[$];
   bit m_frame[$];
   bit m_primed = 1'b0;
   int m_off = 0;
   bit m_rb = 1'b0;
   logic [CW-1:0] m_cnt = '0;

   // scoreboard queues
   bit e_rb[$];
   bit e_del[$];
   bit e_rep[$];
   logic [CW-1:0] e_cnt[$];
   string e_tag[$];
   int seen_del = 0, seen_rep = 0;

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic model_step(input bit wr, input bit wb, input bit rd, input bit clr);
      bit rok, wok, mdel, mrep;
      int f;
      f = m_q.size();
      rok = rd && m_primed && (f != 0);
      wok = wr && ((f != DEPTH) || rok);
      if (rok) begin
         m_rb = m_q.pop_front();
         m_frame.push_back(m_rb);
      end else if (rd) m_rb = 1'b0;
      if (wok) m_q.push_back(wb);
      if (!m_primed && m_q.size() >= FRAME) m_primed = 1'b1;
      mdel = 1'b0; mrep = 1'b0;
      if (rok) begin
         m_off++;
         if (m_off == FRAME) begin
            m_off = 0;
            f = m_q.size();
            if (f < LOW) begin
               mrep = 1'b1;
               for (int i = FRAME - 1; i >= 0; i--) m_q.push_front(m_frame[i]);
            end else if (f > HIGH) begin
               mdel = 1'b1;
               for (int i = 0; i < FRAME; i++) void'(m_q.pop_front());
            end
            m_frame.delete();
         end
      end
      if (clr) m_cnt = '0;
      else if ((mdel || mrep) && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
      e_rb.push_back(m_rb);
      e_del.push_back(mdel);
      e_rep.push_back(mrep);
      e_cnt.push_back(m_cnt);
      e_tag.push_back(cur_tag);
   endtask

   task automatic step(input bit wr, input bit rd, input bit clr);
      bit wb;
      @(negedge clk);
      wb = 1'($urandom);
      wr_en = wr; wr_bit = wb; rd_en = rd; clr_cnt = clr;
      model_step(wr, wb, rd, clr);
   endtask

   // monitor: compare each result one ns after the edge it was produced on
   always @(posedge clk) begin
      if (e_rb.size() > 0) begin
         string t;
         #1;
         t = e_tag.pop_front();
         check(t, "rd_bit (R3)", int'(rd_bit), int'(e_rb.pop_front()));
         check(t, "slip_del (R4)", int'(slip_del), int'(e_del.pop_front()));
         check(t, "slip_rep (R5)", int'(slip_rep), int'(e_rep.pop_front()));
         check(t, "slip_cnt (R7)", int'(slip_cnt), int'(e_cnt.pop_front()));
         if (slip_del) seen_del++;
         if (slip_rep) seen_rep++;
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung, got no end expected end");
         finish_run();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", "rd_bit in reset", int'(rd_bit), 0);
      check("R1", "slip pulses in reset", int'(slip_del | slip_rep), 0);
      check("R1", "slip_cnt in reset", int'(slip_cnt), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "rd_bit after release", int'(rd_bit), 0);
      check("R1", "slip_cnt after release", int'(slip_cnt), 0);

      // R2: reads before priming are ignored
      cur_tag = "R2";
      for (int i = 0; i < FRAME + 2; i++) step(1'b1, 1'b1, 1'b0);

      // R3: balanced rates, simultaneous read and write
      cur_tag = "R3";
      for (int i = 0; i < 6 * FRAME; i++) step(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 20; i++) step(1'($urandom), 1'b0, 1'b0);
      for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0);

      // R4 / R7: fast writer produces deletes until the counter saturates
      cur_tag = "R4";
      for (int i = 0; i < 1400; i++) step(1'b1, (i % 8) != 7, 1'b0);
      @(posedge clk); #2;
      check("R7", "slip_cnt saturated", int'(slip_cnt), int'(CMAX));

      // R8: clear held while deletes continue; clear wins
      cur_tag = "R8";
      for (int i = 0; i < 200; i++) step(1'b1, (i % 8) != 7, 1'b1);
      step(1'b1, 1'b1, 1'b0);

      // R5: slow writer produces repeats
      cur_tag = "R5";
      for (int i = 0; i < 1400; i++) step((i % 8) != 7, 1'b1, 1'b0);

      // R9: fill beyond full, then drain past empty
      cur_tag = "R9";
      for (int i = 0; i < DEPTH + 10; i++) step(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 3 * DEPTH; i++) step(1'b0, 1'b1, 1'b0);
      for (int i = 0; i < FRAME + 5; i++) step(1'b0, 1'b1, 1'b0);
      cur_tag = "R3";
      for (int i = 0; i < 4 * FRAME; i++) step(1'b1, 1'b1, 1'b0);

      step(1'b0, 1'b0, 1'b0);
      repeat (3) @(posedge clk);
      #2;
      check("R4", "delete slips observed (nonzero)", int'(seen_del > 0), 1);
      check("R5", "repeat slips observed (nonzero)", int'(seen_rep > 0), 1);
      check("R6", "scoreboard drained", e_rb.size(), 0);
      done = 1'b1;
      finish_run();
   end

endmodule